// File: doc/BRIEF.md
# Flag-filtered L0 instruction buffer

This block is a tiny fully associative instruction store placed between a processor's fetch unit and a slower next-level instruction memory, such as a cache or a ROM. Each fetch address is compared against every stored entry in one cycle. On a match, the instruction goes back to the core in that same cycle. The next-level memory sees no request at all, so it stays idle and spends no energy on that fetch.

On a mismatch, the core is stalled and the address is forwarded downstream over a valid/ready request channel. The response arrives after a variable number of cycles, marked by a single-cycle strobe. It carries the instruction word and one extra flag bit. The word is passed straight through to the core in the cycle it arrives. It is written into the buffer only when the flag is 1. Because of this, instructions the program rarely reuses never displace the ones it loops over.

Entries are replaced in a fixed circular order. A synchronous flush input empties the buffer. Hit and miss counts are exposed so that the energy saving can be measured. The number of entries is a parameter intended for the 32 to 64 range.

Top module: `l0_insn_buffer`

## Requirements
- R1: While idle, a valid fetch whose address matches a stored entry (and `flush_i` is low) returns that entry's word on `core_rsp_insn_o` with `core_rsp_valid_o` and `core_req_ready_o` high in the same cycle.
- R2: A fetch that hits the buffer never raises `mem_req_valid_o`, neither in its own cycle nor in the following one.
- R3: A fetch that misses raises `mem_req_valid_o` from the next cycle on, carrying the fetch address on `mem_req_addr_o`. Valid and address are held until `mem_req_ready_i` is seen high. `core_req_ready_o` stays low until the response arrives.
- R4: In the cycle `mem_rsp_valid_i` arrives for an outstanding miss, `core_rsp_valid_o` and `core_req_ready_o` are high and `core_rsp_insn_o` equals `mem_rsp_insn_i`. Between the accepted request and the response, `mem_req_valid_o` and `core_rsp_valid_o` are low.
- R5: A returned word is stored only when `mem_rsp_cacheable_i` is 1 in its response cycle. A later fetch of a word returned with the flag at 0 misses again.
- R6: Fills go to the entries in circular order, and the order advances only on a fill. After the buffer is full, the next fill evicts the oldest entry stored since the last flush, while younger entries still hit.
- R7: `flush_i` invalidates every entry in one cycle. A lookup in the flush cycle is handled as a miss. A response arriving in a flush cycle is delivered but not stored.
- R8: `hit_count_o` rises by one, one cycle after each hit response. `miss_count_o` rises by one, one cycle after each miss response.
- R9: After reset the buffer is empty, both counters read 0, and `core_rsp_valid_o` and `mem_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| flush_i | input | 1 | Invalidate all entries this cycle |
| core_req_valid_i | input | 1 | Core fetch request valid |
| core_req_addr_i | input | ADDR_W | Core fetch word address |
| core_req_ready_o | output | 1 | Fetch accepted and completed this cycle |
| core_rsp_valid_o | output | 1 | Instruction returned to core |
| core_rsp_insn_o | output | INSN_W | Instruction word to core |
| mem_req_valid_o | output | 1 | Downstream request valid |
| mem_req_ready_i | input | 1 | Downstream accepts request |
| mem_req_addr_o | output | ADDR_W | Downstream request address |
| mem_rsp_valid_i | input | 1 | Downstream response strobe |
| mem_rsp_insn_i | input | INSN_W | Downstream instruction word |
| mem_rsp_cacheable_i | input | 1 | Flag: store this word in the buffer |
| hit_count_o | output | CNT_W | Number of buffer hits |
| miss_count_o | output | CNT_W | Number of completed misses |

## Verification
The assertions rely on two assumptions about the surrounding blocks. First, the core keeps its request valid and its address steady while `core_req_ready_o` is low. Second, the downstream memory answers each accepted request exactly once, at the earliest one cycle after acceptance, and never raises its response strobe otherwise. The bench's stimulus respects both: it holds the fetch inputs for the whole miss, and it raises the response strobe only after the request handshake, with random gaps before acceptance and before the response. Within those rules it also places flushes on lookup cycles and on response cycles.

// File: rtl/l0b_pkg.sv
package l0b_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } l0b_state_e;
endpackage

// File: rtl/l0b_tag_array.sv
module l0b_tag_array #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 16,
  parameter int INSN_W  = 16,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [INSN_W-1:0] fill_insn_i,
  output logic              hit_o,
  output logic [INSN_W-1:0] hit_insn_o
);

  logic [ENTRIES-1:0] match;
  logic [INSN_W-1:0]  masked [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              vld_q;
    logic              vld_d;
    logic              wr_en;
    logic [ADDR_W-1:0] tag_q;
    logic [INSN_W-1:0] dat_q;

    assign wr_en = fill_en_i && !flush_i && (fill_idx_i == IDX_W'(e));

    always_comb begin
      vld_d = vld_q;
      if (flush_i)    vld_d = 1'b0;
      else if (wr_en) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q <= fill_addr_i;
        dat_q <= fill_insn_i;
      end
    end

    assign match[e]  = vld_q && (tag_q == lookup_addr_i);
    assign masked[e] = match[e] ? dat_q : '0;
  end

  always_comb begin
    hit_insn_o = '0;
    for (int i = 0; i < ENTRIES; i++) hit_insn_o = hit_insn_o | masked[i];
  end

  assign hit_o = |match;

  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !hit_o);

endmodule

// File: rtl/l0b_victim_ptr.sv
module l0b_victim_ptr #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (advance_i) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
      else                               ptr_d = ptr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign idx_o = ptr_q;

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= IDX_W'(ENTRIES - 1));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(ptr_q));

endmodule

// File: rtl/l0b_ctrl.sv
module l0b_ctrl
  import l0b_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int INSN_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              core_req_valid_i,
  input  logic [ADDR_W-1:0] core_req_addr_i,
  output logic              core_req_ready_o,
  output logic              core_rsp_valid_o,
  output logic [INSN_W-1:0] core_rsp_insn_o,
  input  logic              hit_i,
  input  logic [INSN_W-1:0] hit_insn_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [INSN_W-1:0] mem_rsp_insn_i,
  input  logic              mem_rsp_cacheable_i,
  output logic              fill_en_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [INSN_W-1:0] fill_insn_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);

  l0b_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;
  logic              hit_inc, miss_inc;
  logic [CNT_W-1:0]  hit_cnt_q, miss_cnt_q;

  always_comb begin
    st_d             = st_q;
    addr_en          = 1'b0;
    core_req_ready_o = 1'b0;
    core_rsp_valid_o = 1'b0;
    core_rsp_insn_o  = '0;
    mem_req_valid_o  = 1'b0;
    fill_en_o        = 1'b0;
    hit_inc          = 1'b0;
    miss_inc         = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (core_req_valid_i) begin
          if (hit_i && !flush_i) begin
            core_req_ready_o = 1'b1;
            core_rsp_valid_o = 1'b1;
            core_rsp_insn_o  = hit_insn_i;
            hit_inc          = 1'b1;
          end else begin
            addr_en = 1'b1;
            st_d    = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        mem_req_valid_o = 1'b1;
        if (mem_req_ready_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid_i) begin
          core_req_ready_o = 1'b1;
          core_rsp_valid_o = 1'b1;
          core_rsp_insn_o  = mem_rsp_insn_i;
          fill_en_o        = mem_rsp_cacheable_i && !flush_i;
          miss_inc         = 1'b1;
          st_d             = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (hit_inc)  hit_cnt_q  <= hit_cnt_q + CNT_W'(1);
      if (miss_inc) miss_cnt_q <= miss_cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= core_req_addr_i;
  end

  assign mem_req_addr_o = addr_q;
  assign fill_addr_o    = addr_q;
  assign fill_insn_o    = mem_rsp_insn_i;
  assign hit_count_o    = hit_cnt_q;
  assign miss_count_o   = miss_cnt_q;

  // R2
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && core_rsp_valid_o && !mem_req_valid_o) |=> !mem_req_valid_o);

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R8
  hit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rsp_valid_o && st_q == ST_IDLE) |=> hit_count_o == $past(hit_count_o) + CNT_W'(1));

  // R8
  miss_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && mem_rsp_valid_i) |=> miss_count_o == $past(miss_count_o) + CNT_W'(1));

endmodule

// File: rtl/l0_insn_buffer.sv
module l0_insn_buffer #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 16,
  parameter int INSN_W  = 16,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              core_req_valid_i,
  input  logic [ADDR_W-1:0] core_req_addr_i,
  output logic              core_req_ready_o,
  output logic              core_rsp_valid_o,
  output logic [INSN_W-1:0] core_rsp_insn_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [INSN_W-1:0] mem_rsp_insn_i,
  input  logic              mem_rsp_cacheable_i,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              hit;
  logic [INSN_W-1:0] hit_insn;
  logic              fill_en;
  logic [ADDR_W-1:0] fill_addr;
  logic [INSN_W-1:0] fill_insn;
  logic [IDX_W-1:0]  victim_idx;

  l0b_tag_array #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .INSN_W(INSN_W), .IDX_W(IDX_W)
  ) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .lookup_addr_i(core_req_addr_i),
    .fill_en_i    (fill_en),
    .fill_idx_i   (victim_idx),
    .fill_addr_i  (fill_addr),
    .fill_insn_i  (fill_insn),
    .hit_o        (hit),
    .hit_insn_o   (hit_insn)
  );

  l0b_victim_ptr #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance_i(fill_en),
    .idx_o    (victim_idx)
  );

  l0b_ctrl #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk                (clk),
    .rst_n              (rst_n),
    .flush_i            (flush_i),
    .core_req_valid_i   (core_req_valid_i),
    .core_req_addr_i    (core_req_addr_i),
    .core_req_ready_o   (core_req_ready_o),
    .core_rsp_valid_o   (core_rsp_valid_o),
    .core_rsp_insn_o    (core_rsp_insn_o),
    .hit_i              (hit),
    .hit_insn_i         (hit_insn),
    .mem_req_valid_o    (mem_req_valid_o),
    .mem_req_ready_i    (mem_req_ready_i),
    .mem_req_addr_o     (mem_req_addr_o),
    .mem_rsp_valid_i    (mem_rsp_valid_i),
    .mem_rsp_insn_i     (mem_rsp_insn_i),
    .mem_rsp_cacheable_i(mem_rsp_cacheable_i),
    .fill_en_o          (fill_en),
    .fill_addr_o        (fill_addr),
    .fill_insn_o        (fill_insn),
    .hit_count_o        (hit_count_o),
    .miss_count_o       (miss_count_o)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid_o |-> core_req_valid_i);

endmodule

// File: tb/test_l0_insn_buffer.sv
module test_l0_insn_buffer;
  localparam int ENTRIES = 32;
  localparam int AW = 16;
  localparam int IW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_ready;
  logic          rsp_valid;
  logic [IW-1:0] rsp_insn;
  logic          mreq_valid;
  logic          mreq_ready;
  logic [AW-1:0] mreq_addr;
  logic          mrsp_valid;
  logic [IW-1:0] mrsp_insn;
  logic          mrsp_cach;
  logic [CW-1:0] hit_cnt;
  logic [CW-1:0] miss_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [AW-1:0] mq[$];
  int m_hits = 0;
  int m_miss = 0;

  always #4 clk = ~clk;

  l0_insn_buffer #(.ENTRIES(ENTRIES), .ADDR_W(AW), .INSN_W(IW), .CNT_W(CW)) i_l0_insn_buffer (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .core_req_valid_i(req_valid), .core_req_addr_i(req_addr),
    .core_req_ready_o(req_ready), .core_rsp_valid_o(rsp_valid), .core_rsp_insn_o(rsp_insn),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready), .mem_req_addr_o(mreq_addr),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_insn_i(mrsp_insn), .mem_rsp_cacheable_i(mrsp_cach),
    .hit_count_o(hit_cnt), .miss_count_o(miss_cnt)
  );

  function automatic logic [IW-1:0] word_of(input logic [AW-1:0] a);
    return (a * 16'h003b) ^ 16'h5a5a;
  endfunction

  function automatic bit m_has(input logic [AW-1:0] a);
    foreach (mq[i]) if (mq[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic m_fill(input logic [AW-1:0] a);
    if (mq.size() == ENTRIES) void'(mq.pop_front());
    mq.push_back(a);
  endtask

  // one fetch; starts and ends just after a falling edge with the core idle
  task automatic fetch(input logic [AW-1:0] a, input bit cach, input int rdly, input int sdly,
                       input bit fl_look, input bit fl_rsp, input string tag);
    bit exp_hit;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; flush = fl_look;
    #1;
    exp_hit = m_has(a) && !fl_look;
    chk(tag, "hit decision", 32'(rsp_valid), 32'(exp_hit));
    chk("R2", "no mem req in lookup cycle", 32'(mreq_valid), 32'h0);
    if (exp_hit) begin
      chk("R1", "hit ready", 32'(req_ready), 32'h1);
      chk("R1", "hit word", 32'(rsp_insn), 32'(word_of(a)));
      @(posedge clk);
      m_hits++;
      @(negedge clk);
      req_valid = 1'b0; flush = 1'b0;
      #1;
      chk("R2", "no mem req after hit", 32'(mreq_valid), 32'h0);
    end else begin
      chk("R3", "core stalled on miss", 32'(req_ready), 32'h0);
      @(posedge clk);
      if (fl_look) mq.delete();
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        flush = 1'b0; mreq_ready = 1'b0;
        #1;
        chk("R3", "mem req held", 32'(mreq_valid), 32'h1);
        chk("R3", "mem addr held", 32'(mreq_addr), 32'(a));
        chk("R3", "core still stalled", 32'(req_ready), 32'h0);
      end
      @(negedge clk);
      flush = 1'b0; mreq_ready = 1'b1;
      #1;
      chk("R3", "mem req at handshake", 32'(mreq_valid), 32'h1);
      chk("R3", "mem addr at handshake", 32'(mreq_addr), 32'(a));
      for (int i = 0; i < sdly; i++) begin
        @(negedge clk);
        mreq_ready = 1'b0;
        #1;
        chk("R4", "no mem req while waiting", 32'(mreq_valid), 32'h0);
        chk("R4", "no core rsp while waiting", 32'(rsp_valid), 32'h0);
      end
      @(negedge clk);
      mreq_ready = 1'b0; mrsp_valid = 1'b1; mrsp_insn = word_of(a); mrsp_cach = cach; flush = fl_rsp;
      #1;
      chk("R4", "bypass valid", 32'(rsp_valid), 32'h1);
      chk("R4", "bypass ready", 32'(req_ready), 32'h1);
      chk("R4", "bypass word", 32'(rsp_insn), 32'(word_of(a)));
      @(posedge clk);
      if (fl_rsp) mq.delete();
      else if (cach) m_fill(a);
      m_miss++;
      @(negedge clk);
      mrsp_valid = 1'b0; mrsp_cach = 1'b0; flush = 1'b0; req_valid = 1'b0;
      #1;
    end
    chk("R8", "hit counter", 32'(hit_cnt), 32'(m_hits));
    chk("R8", "miss counter", 32'(miss_cnt), 32'(m_miss));
    chk("R2", "idle core rsp low", 32'(rsp_valid), 32'h0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b0;
    @(posedge clk);
    mq.delete();
    @(negedge clk);
    flush = 1'b0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_addr = '0;
    mreq_ready = 1'b0; mrsp_valid = 1'b0; mrsp_insn = '0; mrsp_cach = 1'b0;
    #1;
    chk("R9", "reset core rsp", 32'(rsp_valid), 32'h0);
    chk("R9", "reset mem req", 32'(mreq_valid), 32'h0);
    chk("R9", "reset hit count", 32'(hit_cnt), 32'h0);
    chk("R9", "reset miss count", 32'(miss_cnt), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R9 empty after reset, R1/R2 hit after cacheable fill
    fetch(16'h0100, 1'b1, 0, 0, 1'b0, 1'b0, "R9");
    fetch(16'h0100, 1'b1, 0, 0, 1'b0, 1'b0, "R1");
    fetch(16'h0100, 1'b1, 0, 0, 1'b0, 1'b0, "R2");

    // R5 flag zero: no allocation
    fetch(16'h0104, 1'b0, 2, 3, 1'b0, 1'b0, "R5");
    fetch(16'h0104, 1'b0, 1, 0, 1'b0, 1'b0, "R5");
    fetch(16'h0104, 1'b1, 0, 2, 1'b0, 1'b0, "R5");
    fetch(16'h0104, 1'b1, 0, 0, 1'b0, 1'b0, "R5");

    // R7 flush in lookup cycle, flush alone, flush in response cycle
    fetch(16'h0100, 1'b1, 0, 1, 1'b1, 1'b0, "R7");
    fetch(16'h0100, 1'b1, 0, 0, 1'b0, 1'b0, "R7");
    do_flush();
    fetch(16'h0100, 1'b1, 1, 1, 1'b0, 1'b1, "R7");
    fetch(16'h0100, 1'b1, 0, 0, 1'b0, 1'b0, "R7");

    // R6 circular replacement: ENTRIES+1 fills after a flush
    do_flush();
    for (int k = 0; k <= ENTRIES; k++)
      fetch(AW'(16'h0200 + 2 * k), 1'b1, k % 2, k % 3, 1'b0, 1'b0, "R6");
    fetch(16'h0202, 1'b1, 0, 0, 1'b0, 1'b0, "R6");
    fetch(AW'(16'h0200 + 2 * ENTRIES), 1'b1, 0, 0, 1'b0, 1'b0, "R6");
    fetch(16'h0200, 1'b1, 0, 0, 1'b0, 1'b0, "R6");
    fetch(16'h0204, 1'b1, 0, 0, 1'b0, 1'b0, "R6");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'(16'h0400 + 4 * ($urandom % 48));
      fetch(a, ($urandom % 4) != 0, $urandom % 3, $urandom % 4,
            ($urandom % 40) == 0, ($urandom % 40) == 0, "R1");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule